// File: doc/BRIEF.md
# Iterative HI/LO Integer Divider

This block performs 32-bit integer division for a processor core, one quotient bit per clock. A decoded divide instruction starts it: with the start strobe it receives the instruction word together with the two register operands. The first operand is the dividend and the second is the divisor. The funct field selects signed or unsigned arithmetic. An instruction word that is not a well-formed divide is ignored.

The quotient goes to a dedicated LO result register and the remainder goes to a dedicated HI result register. Both registers can be read on their ports at any time, and they keep their previous contents until a division completes. While a division runs the block holds `busy_o` high. It pulses `done_o` for one cycle when the new results appear.

Internally the block divides the operand magnitudes with a restoring algorithm over 32 iterations. One final cycle applies the signs and writes HI and LO. Division by zero and the overflow case of the most negative value divided by minus one finish in the normal time. Neither raises an exception.

Top module: `hilo_divider`

## Requirements
- R1: A start is accepted only when the instruction has opcode bits [31:26] = 000000, bits [15:11] = 0, bits [10:6] = 0 and funct bits [5:0] equal to 011010 (signed) or 011011 (unsigned). Any other word leaves `busy_o` low and HI/LO unchanged.
- R2: Unsigned mode treats both operands as 32-bit unsigned values and writes the quotient to LO and the remainder to HI.
- R3: Signed mode truncates the quotient toward zero. The remainder is written to HI and carries the sign of the dividend. The quotient is written to LO.
- R4: After an accepted start, `busy_o` is high for exactly 33 cycles, beginning in the cycle after the start edge. In the first cycle with `busy_o` low again, `done_o` is high for that one cycle only and the new HI/LO values are visible.
- R5: A start strobe that arrives while `busy_o` is high is ignored. It neither restarts nor alters the division in progress.
- R6: HI and LO change only in the cycle in which `done_o` is high. At all other times they keep their previous values.
- R7: A zero divisor gives HI equal to the dividend. LO is all ones in unsigned mode. In signed mode LO is 1 for a negative dividend and all ones otherwise.
- R8: A signed division of 0x80000000 by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R9: While reset is high, and in the cycle after it is released, `busy_o` and `done_o` are low and HI and LO read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe for a decoded instruction |
| instr_i | input | 32 | Instruction word presented with the strobe |
| rs_val_i | input | 32 | Dividend operand value |
| rt_val_i | input | 32 | Divisor operand value |
| busy_o | output | 1 | High while a division is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | HI register (remainder) |
| lo_o | output | 32 | LO register (quotient) |

## Verification
The assertions check the handshake on every cycle. Each run of `busy_o` must last exactly 33 cycles, even when start strobes arrive mid-run. `done_o` must coincide with the falling edge of `busy_o`, and HI/LO must hold unless `done_o` is high. The arithmetic itself can only be shown by the bench's scenarios: unsigned and signed results for every sign combination, rejected instruction encodings, a zero divisor, and the most-negative by minus-one case. Each of these is compared against values the bench computes from the requirements.

// File: rtl/hilo_div_pkg.sv
package hilo_div_pkg;

    localparam int INSTR_W = 32;

    localparam logic [5:0] OPC_REGFMT  = 6'b000000;
    localparam logic [5:0] FN_DIV_SGN  = 6'b011010;
    localparam logic [5:0] FN_DIV_UNS  = 6'b011011;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_e;

    typedef struct packed {
        logic [5:0] opcode;
        logic [4:0] dst;
        logic [4:0] shift;
        logic [5:0] funct;
    } instr_fields_t;

    typedef struct packed {
        logic valid;
        logic is_signed;
    } div_cmd_t;

    function automatic instr_fields_t split_instr(input logic [INSTR_W-1:0] w);
        instr_fields_t f;
        f.opcode = w[31:26];
        f.dst    = w[15:11];
        f.shift  = w[10:6];
        f.funct  = w[5:0];
        return f;
    endfunction

    function automatic logic is_div_funct(input logic [5:0] fn);
        return (fn == FN_DIV_SGN) || (fn == FN_DIV_UNS);
    endfunction

endpackage

// File: rtl/hilo_div_decode.sv
module hilo_div_decode
    import hilo_div_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output div_cmd_t           cmd_o
);
    instr_fields_t f;
    logic          unused_reg_fields;

    assign unused_reg_fields = ^instr_i[25:16];

    always_comb begin
        f               = split_instr(instr_i);
        cmd_o.valid     = (f.opcode == OPC_REGFMT) && (f.dst == '0) &&
                          (f.shift == '0) && is_div_funct(f.funct);
        cmd_o.is_signed = (f.funct == FN_DIV_SGN);
    end
endmodule

// File: rtl/hilo_div_step.sv
module hilo_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] dvs_i,
    output logic [W-1:0] rem_o,
    output logic         qbit_o
);
    logic [W:0]   shifted;
    logic [W+1:0] trial;

    always_comb begin
        shifted = {rem_i, bit_i};
        trial   = {1'b0, shifted} - {2'b00, dvs_i};
        qbit_o  = ~trial[W+1];
        rem_o   = qbit_o ? trial[W-1:0] : shifted[W-1:0];
    end
endmodule

// File: rtl/hilo_div_seq.sv
module hilo_div_seq
    import hilo_div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         accept_i,
    input  div_cmd_t     cmd_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         fix_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o,
    output logic         neg_q_o,
    output logic         neg_r_o
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    div_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic [W-1:0]  quo_q, rem_q, dvs_q;
    logic          negq_q, negr_q;
    logic [W-1:0]  rem_nx;
    logic          qbit;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic sgn);
        return (sgn && x[W-1]) ? (~x + 1'b1) : x;
    endfunction

    hilo_div_step #(.W(W)) u_step (
        .rem_i (rem_q),
        .bit_i (quo_q[W-1]),
        .dvs_i (dvs_q),
        .rem_o (rem_nx),
        .qbit_o(qbit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            negq_q  <= 1'b0;
            negr_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept_i) begin
                        quo_q   <= magnitude(dvd_i, cmd_i.is_signed);
                        dvs_q   <= magnitude(dvs_i, cmd_i.is_signed);
                        rem_q   <= '0;
                        cnt_q   <= '0;
                        negq_q  <= cmd_i.is_signed & (dvd_i[W-1] ^ dvs_i[W-1]);
                        negr_q  <= cmd_i.is_signed & dvd_i[W-1];
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    rem_q <= rem_nx;
                    quo_q <= {quo_q[W-2:0], qbit};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o  = (state_q != ST_IDLE);
    assign fix_o   = (state_q == ST_FIX);
    assign quo_o   = quo_q;
    assign rem_o   = rem_q;
    assign neg_q_o = negq_q;
    assign neg_r_o = negr_q;
endmodule

// File: rtl/hilo_divider.sv
module hilo_divider
    import hilo_div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [W-1:0]       rs_val_i,
    input  logic [W-1:0]       rt_val_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [W-1:0]       hi_o,
    output logic [W-1:0]       lo_o
);
    div_cmd_t     cmd;
    logic         accept, fix, neg_q, neg_r, busy;
    logic [W-1:0] quo, rem;
    logic [W-1:0] hi_q, lo_q;
    logic         done_q;

    hilo_div_decode u_dec (
        .instr_i(instr_i),
        .cmd_o  (cmd)
    );

    assign accept = start_i & cmd.valid & ~busy;

    hilo_div_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .accept_i(accept),
        .cmd_i   (cmd),
        .dvd_i   (rs_val_i),
        .dvs_i   (rt_val_i),
        .busy_o  (busy),
        .fix_o   (fix),
        .quo_o   (quo),
        .rem_o   (rem),
        .neg_q_o (neg_q),
        .neg_r_o (neg_r)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q   <= '0;
            lo_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fix;
            if (fix) begin
                lo_q <= neg_q ? (~quo + 1'b1) : quo;
                hi_q <= neg_r ? (~rem + 1'b1) : rem;
            end
        end
    end

    assign busy_o = busy;
    assign done_o = done_q;
    assign hi_o   = hi_q;
    assign lo_o   = lo_q;
endmodule

// File: rtl/hilo_divider_chk.sv
module hilo_divider_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] hi_o,
    input logic [W-1:0] lo_o
);
    localparam int RUN_LEN = W + 1;
    localparam int BW      = $clog2(RUN_LEN + 2);

    logic [BW-1:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)         busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 1'b1;
        else             busy_cnt <= '0;
    end

    p_busy_len_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> (busy_cnt == BW'(RUN_LEN)));

    p_busy_no_overrun_r5: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (busy_cnt < BW'(RUN_LEN)));

    p_done_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        done_o == $fell(busy_o));

    p_done_not_busy_r4: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_hilo_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind hilo_divider hilo_divider_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .busy_o(busy_o),
    .done_o(done_o),
    .hi_o  (hi_o),
    .lo_o  (lo_o)
);

// File: tb/hilo_divider_tb.sv
module hilo_divider_tb;
    localparam logic [5:0] FN_S = 6'b011010;
    localparam logic [5:0] FN_U = 6'b011011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] rs = '0;
    logic [31:0] rt = '0;
    logic        busy, done;
    logic [31:0] hi, lo;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    hilo_divider u_dut (
        .clk(clk), .rst(rst), .start_i(start), .instr_i(instr),
        .rs_val_i(rs), .rt_val_i(rt),
        .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rd,
                                       input logic [4:0] sh, input logic [5:0] fn);
        return {op, 5'd4, 5'd5, rd, sh, fn};
    endfunction

    task automatic expect_div(input bit sgn, input logic [31:0] a, input logic [31:0] b,
                              output logic [31:0] q, output logic [31:0] r);
        if (b == 0) begin
            r = a;
            q = (sgn && a[31]) ? 32'd1 : 32'hFFFF_FFFF;
        end else if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            q = 32'h8000_0000;
            r = 32'h0;
        end else if (sgn) begin
            q = $signed(a) / $signed(b);
            r = $signed(a) % $signed(b);
        end else begin
            q = a / b;
            r = a % b;
        end
    endtask

    // Runs one division; poke > 0 issues an extra start strobe in that busy cycle.
    task automatic do_div(input string req, input bit sgn, input logic [31:0] a,
                          input logic [31:0] b, input int poke);
        logic [31:0] eq, er, hold_hi, hold_lo;
        int nb;
        bit hold_ok;
        expect_div(sgn, a, b, eq, er);
        @(negedge clk);
        hold_hi = hi;
        hold_lo = lo;
        instr = mk(6'b0, 5'd0, 5'd0, sgn ? FN_S : FN_U);
        rs = a;
        rt = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        nb = 0;
        hold_ok = 1;
        while (busy && nb < 100) begin
            nb++;
            if (hi !== hold_hi || lo !== hold_lo) hold_ok = 0;
            if (poke > 0 && nb == poke) begin
                start = 1'b1;
                rs = 32'h1234_5678;
                rt = 32'd3;
                instr = mk(6'b0, 5'd0, 5'd0, FN_U);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk({req, " R4 busy cycles"}, 32'(nb), 32'd33);
        chk({req, " R6 HI/LO held while busy"}, {31'd0, hold_ok}, 32'd1);
        chk({req, " R4 done pulse"}, {31'd0, done}, 32'd1);
        chk({req, " LO"}, lo, eq);
        chk({req, " HI"}, hi, er);
        @(negedge clk);
        chk({req, " R4 done single cycle"}, {31'd0, done}, 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R9 busy in reset", {31'd0, busy}, 32'd0);
        chk("R9 done in reset", {31'd0, done}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 HI after reset", hi, 32'd0);
        chk("R9 LO after reset", lo, 32'd0);
        chk("R9 busy after reset", {31'd0, busy}, 32'd0);
    endtask

    task automatic t_unsigned();
        do_div("R2 100/7", 1'b0, 32'd100, 32'd7, 0);
        do_div("R2 big/small", 1'b0, 32'hFFFF_FFFF, 32'd10, 0);
        do_div("R2 small/big", 1'b0, 32'd5, 32'h8000_0000, 0);
        do_div("R2 high divisor", 1'b0, 32'hF000_0001, 32'hC000_0000, 0);
    endtask

    task automatic t_signed();
        do_div("R3 +/+", 1'b1, 32'd7, 32'd2, 0);
        do_div("R3 -/+", 1'b1, -32'sd7, 32'd2, 0);
        do_div("R3 +/-", 1'b1, 32'd7, -32'sd2, 0);
        do_div("R3 -/-", 1'b1, -32'sd7, -32'sd2, 0);
        do_div("R3 minneg/3", 1'b1, 32'h8000_0000, 32'd3, 0);
    endtask

    task automatic t_divzero();
        do_div("R7 unsigned /0", 1'b0, 32'hDEAD_BEEF, 32'd0, 0);
        do_div("R7 signed neg /0", 1'b1, -32'sd9, 32'd0, 0);
        do_div("R7 signed pos /0", 1'b1, 32'd9, 32'd0, 0);
    endtask

    task automatic t_minneg();
        do_div("R8 minneg/-1", 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, 0);
    endtask

    task automatic t_busy_restart();
        do_div("R5 start while busy", 1'b0, 32'd1000, 32'd9, 10);
    endtask

    task automatic t_bad_decode();
        logic [31:0] bad [4];
        logic [31:0] h0, l0;
        bad[0] = mk(6'b000001, 5'd0, 5'd0, FN_S);
        bad[1] = mk(6'b0, 5'd3, 5'd0, FN_U);
        bad[2] = mk(6'b0, 5'd0, 5'd1, FN_S);
        bad[3] = mk(6'b0, 5'd0, 5'd0, 6'b011000);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            h0 = hi;
            l0 = lo;
            instr = bad[i];
            rs = 32'd50;
            rt = 32'd4;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R1 rejected word busy", {31'd0, busy}, 32'd0);
            repeat (3) @(negedge clk);
            chk("R1 rejected word HI", hi, h0);
            chk("R1 rejected word LO", lo, l0);
            chk("R1 rejected word done", {31'd0, done}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_unsigned();
        t_signed();
        t_divzero();
        t_minneg();
        t_busy_restart();
        t_bad_decode();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule